// File: doc/BRIEF.md
# Line-Wide In-Memory Compute Array

This block is a small array of wide memory lines with an operation unit next to it. A compute command names an operation, a lane width, up to two source lines and one destination line. The block reads the source lines, applies the operation to the whole line at once, and writes the result into the destination line. The whole line is processed together, so the width of the operation is the line width and not a processor word width.

Bitwise operations act on every bit of the line. Arithmetic operations split the line into packed lanes of 8, 16, 32 or 64 bits, and no carry or borrow crosses a lane boundary. A command takes a fixed three cycles after it is accepted: source fetch, compute, and write-back. `busy` is high for all three cycles, and `done` pulses in the last one. A conventional port gives ordinary single-line reads and writes while no command is running.

Top module: `lim_array_top`

## Requirements
- R1: A conventional read accepted on a clock edge returns the line on `mem_rdata` with `mem_rvalid` high for the following cycle. A conventional write stores `mem_wdata` into the addressed line. An access is accepted when `mem_en` is high, `busy` is low and `cmd_valid` is low.
- R2: A command is accepted on an edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly three cycles, and `done` is high only in the third of them. The destination line holds the result from the cycle after `done`.
- R3: Bitwise opcodes act on every bit of the line: 0 inverts source 1; 5 XOR, 6 XNOR, 7 AND, 8 OR, 9 NOR, 10 NAND of source 1 with source 2.
- R4: Opcode 1 writes all ones and opcode 2 writes all zeros to the destination, whatever the sources hold.
- R5: Opcode 3 moves source 1 one bit toward the most significant end, and opcode 4 moves it one bit toward the least significant end. The bit vacated at either end is filled with zero.
- R6: Opcode 11 adds and opcode 12 subtracts (source 1 minus source 2) per lane, modulo the lane size. Lane code 0, 1, 2 and 3 selects lanes of 8, 16, 32 and 64 bits, with lane 0 in the least significant bits. No carry or borrow crosses a lane boundary. The destination may equal a source.
- R7: Opcode 13 adds one to, and opcode 14 subtracts one from, each lane of source 1, modulo the lane size. Source 2 has no effect.
- R8: Opcode 15 writes, in each lane, all ones when the source 1 and source 2 lanes are equal and all zeros otherwise.
- R9: While `busy` is high, conventional reads and writes are refused: no line changes and `mem_rvalid` stays low. A command presented while `busy` is high is also ignored.
- R10: When a command and a conventional access are presented on the same idle edge, the command is accepted and the conventional access is refused.
- R11: During and right after reset, `busy`, `done` and `mem_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Compute command present |
| cmd_op | input | 4 | Operation code |
| cmd_lane | input | 2 | Lane width code for arithmetic |
| cmd_src1 | input | AW | First source line |
| cmd_src2 | input | AW | Second source line |
| cmd_dst | input | AW | Destination line |
| busy | output | 1 | Command in progress |
| done | output | 1 | Write-back cycle of a command |
| mem_en | input | 1 | Conventional access request |
| mem_we | input | 1 | Conventional access is a write |
| mem_addr | input | AW | Conventional access line |
| mem_wdata | input | LINE_W | Conventional write data |
| mem_rdata | output | LINE_W | Conventional read data |
| mem_rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with a 128-bit line and eight lines. Each line then holds exactly two 64-bit lanes, sixteen 8-bit lanes, and so on. Every lane-boundary carry case is reachable with short hand-picked patterns, and a few scratch lines are enough for a full sweep. The sweep runs all sixteen opcodes with all four lane codes over several source pairs, including all-ones and single-bit patterns that make carries and borrows stop at every lane edge. The sweep also covers an in-place update. The expected lines come from per-lane arithmetic done in the bench, and the busy and done sequence is checked on every command.

// File: rtl/lim_pkg.sv
package lim_pkg;

   typedef enum logic [3:0] {
      OP_INV   = 4'd0,
      OP_FILL1 = 4'd1,
      OP_FILL0 = 4'd2,
      OP_SHL   = 4'd3,
      OP_SHR   = 4'd4,
      OP_XOR   = 4'd5,
      OP_XNOR  = 4'd6,
      OP_AND   = 4'd7,
      OP_OR    = 4'd8,
      OP_NOR   = 4'd9,
      OP_NAND  = 4'd10,
      OP_ADD   = 4'd11,
      OP_SUB   = 4'd12,
      OP_INC   = 4'd13,
      OP_DEC   = 4'd14,
      OP_EQ    = 4'd15
   } lim_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_EXEC  = 2'd2,
      ST_STORE = 2'd3
   } lim_state_e;

   localparam int LIM_NUM_LANE_SEL = 4;

   function automatic logic lim_is_arith(lim_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) ||
             (op == OP_DEC) || (op == OP_EQ);
   endfunction

endpackage

// File: rtl/lim_store.sv
module lim_store #(
   parameter int LINE_W = 256,
   parameter int DEPTH  = 16,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_we,
   input  logic [AW-1:0]     conv_addr,
   input  logic [LINE_W-1:0] conv_data,
   input  logic              wb_we,
   input  logic [AW-1:0]     wb_addr,
   input  logic [LINE_W-1:0] wb_data,
   input  logic [AW-1:0]     rd_a_addr,
   input  logic [AW-1:0]     rd_b_addr,
   output logic [LINE_W-1:0] rd_a,
   output logic [LINE_W-1:0] rd_b
);

   logic [LINE_W-1:0] lines [DEPTH];

   always_ff @(posedge clk) begin
      if (wb_we) begin
         lines[wb_addr] <= wb_data;
      end else if (conv_we) begin
         lines[conv_addr] <= conv_data;
      end
   end

   assign rd_a = lines[rd_a_addr];
   assign rd_b = lines[rd_b_addr];

   // R9: the conventional port never writes in a cycle that the command path owns
   p_single_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_we && conv_we));

endmodule

// File: rtl/lim_logic_unit.sv
module lim_logic_unit
   import lim_pkg::*;
#(
   parameter int LINE_W = 256
) (
   input  lim_op_e           op,
   input  logic [LINE_W-1:0] a,
   input  logic [LINE_W-1:0] b,
   output logic [LINE_W-1:0] res
);

   always_comb begin
      unique case (op)
         OP_INV:   res = ~a;
         OP_FILL1: res = '1;
         OP_FILL0: res = '0;
         OP_SHL:   res = {a[LINE_W-2:0], 1'b0};
         OP_SHR:   res = {1'b0, a[LINE_W-1:1]};
         OP_XOR:   res = a ^ b;
         OP_XNOR:  res = ~(a ^ b);
         OP_AND:   res = a & b;
         OP_OR:    res = a | b;
         OP_NOR:   res = ~(a | b);
         OP_NAND:  res = ~(a & b);
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/lim_lane_alu.sv
module lim_lane_alu
   import lim_pkg::*;
#(
   parameter int LINE_W = 256,
   parameter int LANE_W = 8,
   localparam int NLANES = LINE_W / LANE_W
) (
   input  lim_op_e           op,
   input  logic [LINE_W-1:0] a,
   input  logic [LINE_W-1:0] b,
   output logic [LINE_W-1:0] res
);

   if ((LINE_W % LANE_W) != 0) begin : g_bad_lane
      $error("lim_lane_alu: LINE_W must be a multiple of LANE_W");
   end

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      logic [LANE_W-1:0] x, y, r;
      assign x = a[i*LANE_W +: LANE_W];
      assign y = b[i*LANE_W +: LANE_W];
      always_comb begin
         unique case (op)
            OP_ADD:  r = x + y;
            OP_SUB:  r = x - y;
            OP_INC:  r = x + LANE_W'(1);
            OP_DEC:  r = x - LANE_W'(1);
            OP_EQ:   r = {LANE_W{x == y}};
            default: r = '0;
         endcase
      end
      assign res[i*LANE_W +: LANE_W] = r;
   end

endmodule

// File: rtl/lim_array_top.sv
module lim_array_top
   import lim_pkg::*;
#(
   parameter int  LINE_W = 256,
   parameter int  DEPTH  = 16,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [1:0]        cmd_lane,
   input  logic [AW-1:0]     cmd_src1,
   input  logic [AW-1:0]     cmd_src2,
   input  logic [AW-1:0]     cmd_dst,
   output logic              busy,
   output logic              done,
   input  logic              mem_en,
   input  logic              mem_we,
   input  logic [AW-1:0]     mem_addr,
   input  logic [LINE_W-1:0] mem_wdata,
   output logic [LINE_W-1:0] mem_rdata,
   output logic              mem_rvalid
);

   if ((LINE_W % 64) != 0 || LINE_W < 64) begin : g_bad_width
      $error("lim_array_top: LINE_W must be a non-zero multiple of 64");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("lim_array_top: DEPTH must be at least 2");
   end

   lim_state_e        state_q;
   lim_op_e           op_q;
   logic [1:0]        lane_q;
   logic [AW-1:0]     src1_q, src2_q, dst_q;
   logic [LINE_W-1:0] opa_q, opb_q, res_q;
   logic [LINE_W-1:0] rd_a, rd_b, logic_res, next_res;
   logic [LINE_W-1:0] lane_res [LIM_NUM_LANE_SEL];
   logic              cmd_take, conv_take, conv_we, wb_we;
   logic [AW-1:0]     rd_a_addr;

   assign cmd_take  = cmd_valid && (state_q == ST_IDLE);
   assign conv_take = mem_en && (state_q == ST_IDLE) && !cmd_valid;
   assign conv_we   = conv_take && mem_we;
   assign wb_we     = (state_q == ST_STORE);
   assign rd_a_addr = (state_q == ST_FETCH) ? src1_q : mem_addr;

   lim_store #(.LINE_W(LINE_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_we   (conv_we),
      .conv_addr (mem_addr),
      .conv_data (mem_wdata),
      .wb_we     (wb_we),
      .wb_addr   (dst_q),
      .wb_data   (res_q),
      .rd_a_addr (rd_a_addr),
      .rd_b_addr (src2_q),
      .rd_a      (rd_a),
      .rd_b      (rd_b)
   );

   lim_logic_unit #(.LINE_W(LINE_W)) u_logic (
      .op  (op_q),
      .a   (opa_q),
      .b   (opb_q),
      .res (logic_res)
   );

   for (genvar g = 0; g < LIM_NUM_LANE_SEL; g++) begin : g_width
      localparam int LW = 8 << g;
      lim_lane_alu #(.LINE_W(LINE_W), .LANE_W(LW)) u_alu (
         .op  (op_q),
         .a   (opa_q),
         .b   (opb_q),
         .res (lane_res[g])
      );
   end

   assign next_res = lim_is_arith(op_q) ? lane_res[lane_q] : logic_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_INV;
         lane_q  <= '0;
         src1_q  <= '0;
         src2_q  <= '0;
         dst_q   <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         res_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_take) begin
                  op_q    <= lim_op_e'(cmd_op);
                  lane_q  <= cmd_lane;
                  src1_q  <= cmd_src1;
                  src2_q  <= cmd_src2;
                  dst_q   <= cmd_dst;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               opa_q   <= rd_a;
               opb_q   <= rd_b;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               res_q   <= next_res;
               state_q <= ST_STORE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rdata  <= '0;
         mem_rvalid <= 1'b0;
      end else begin
         mem_rvalid <= conv_take && !mem_we;
         if (conv_take && !mem_we) begin
            mem_rdata <= rd_a;
         end
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_STORE);

   // R2: done follows the start of busy by exactly two cycles
   p_busy_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ##2 done);
   // R2: busy ends right after done, and done lasts one cycle
   p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));
   // R9: no read data is returned for a request made while busy
   p_refuse_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_en) |=> !mem_rvalid);
   // R10: a command wins over a conventional access on the same edge
   p_cmd_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> (busy && !mem_rvalid));
   // R1: an accepted read returns data on the next cycle
   p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && !busy && !cmd_valid) |=> mem_rvalid);

endmodule

// File: tb/tb_lim_array_top.sv
`timescale 1ns/1ps
module tb_lim_array_top;

   localparam int LW = 128;
   localparam int DP = 8;
   localparam int AW = $clog2(DP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_op = '0;
   logic [1:0]    cmd_lane = '0;
   logic [AW-1:0] cmd_src1 = '0, cmd_src2 = '0, cmd_dst = '0;
   logic          busy, done;
   logic          mem_en = 1'b0, mem_we = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [LW-1:0] mem_wdata = '0;
   logic [LW-1:0] mem_rdata;
   logic          mem_rvalid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [LW-1:0] model [DP];
   logic [LW-1:0] rd_val;

   always #4 clk = ~clk;

   lim_array_top #(.LINE_W(LW), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_lane(cmd_lane), .cmd_src1(cmd_src1), .cmd_src2(cmd_src2),
      .cmd_dst(cmd_dst), .busy(busy), .done(done), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   task automatic chk(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(int op);
      if (op == 1 || op == 2) return "R4";
      if (op == 3 || op == 4) return "R5";
      if (op == 11 || op == 12) return "R6";
      if (op == 13 || op == 14) return "R7";
      if (op == 15) return "R8";
      return "R3";
   endfunction

   function automatic logic [LW-1:0] ref_op(int op, int lane, logic [LW-1:0] a, logic [LW-1:0] b);
      logic [LW-1:0] out, m, x, y, r;
      int w;
      case (op)
         0:  return ~a;
         1:  return '1;
         2:  return '0;
         3:  return a << 1;
         4:  return a >> 1;
         5:  return a ^ b;
         6:  return ~(a ^ b);
         7:  return a & b;
         8:  return a | b;
         9:  return ~(a | b);
         10: return ~(a & b);
         default: ;
      endcase
      w = 8 << lane;
      m = (LW'(1) << w) - LW'(1);
      out = '0;
      for (int i = 0; i < LW / w; i++) begin
         x = (a >> (i * w)) & m;
         y = (b >> (i * w)) & m;
         case (op)
            11: r = x + y;
            12: r = x - y;
            13: r = x + 1;
            14: r = x - 1;
            default: r = (x == y) ? m : '0;
         endcase
         out = out | ((r & m) << (i * w));
      end
      return out;
   endfunction

   task automatic conv_write(int addr, logic [LW-1:0] d);
      @(negedge clk);
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = AW'(addr); mem_wdata = d;
      @(negedge clk);
      mem_en = 1'b0; mem_we = 1'b0;
      model[addr] = d;
   endtask

   task automatic conv_read(int addr, string req);
      @(negedge clk);
      mem_en = 1'b1; mem_we = 1'b0; mem_addr = AW'(addr);
      @(negedge clk);
      mem_en = 1'b0;
      rd_val = mem_rdata;
      chk(mem_rvalid === 1'b1, {req, " rvalid"}, LW'(mem_rvalid), LW'(1));
      chk(mem_rdata === model[addr], req, mem_rdata, model[addr]);
   endtask

   task automatic run_cmd(int op, int lane, int s1, int s2, int d);
      logic [7:0] seq;
      logic [LW-1:0] exp;
      exp = ref_op(op, lane, model[s1], model[s2]);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'(op); cmd_lane = 2'(lane);
      cmd_src1 = AW'(s1); cmd_src2 = AW'(s2); cmd_dst = AW'(d);
      @(negedge clk);
      cmd_valid = 1'b0;
      seq[7:6] = {busy, done};
      @(negedge clk);
      seq[5:4] = {busy, done};
      @(negedge clk);
      seq[3:2] = {busy, done};
      @(negedge clk);
      seq[1:0] = {busy, done};
      chk(seq === 8'b10_10_11_00, "R2 busy/done sequence", LW'(seq), LW'(8'b10101100));
      model[d] = exp;
      conv_read(d, req_of(op));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [LW-1:0] pat [7];
      pat[0] = '1;
      pat[1] = {16{8'h01}};
      pat[2] = '0;
      pat[3] = 128'h80000000_00000001_80000000_00000001;
      pat[4] = 128'h01234567_89abcdef_fedcba98_76543210;
      pat[5] = 128'hffffffff_ffffffff_00000000_00000001;
      pat[6] = 128'h7f80ff00_8000ffff_00ff7fff_80000001;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk({busy, done, mem_rvalid} === 3'b000, "R11 in reset", LW'({busy, done, mem_rvalid}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, mem_rvalid} === 3'b000, "R11 after reset", LW'({busy, done, mem_rvalid}), '0);

      // R1: fill and read back every line
      for (int i = 0; i < 7; i++) conv_write(i, pat[i]);
      conv_write(7, ~pat[4]);
      for (int i = 0; i < DP; i++) conv_read(i, "R1");

      // Sweep every opcode and lane code over several source pairs
      for (int op = 0; op < 16; op++) begin
         for (int lane = 0; lane < 4; lane++) begin
            run_cmd(op, lane, 0, 1, 7);
            run_cmd(op, lane, 4, 5, 7);
            run_cmd(op, lane, 6, 3, 7);
            run_cmd(op, lane, 2, 0, 7);
            run_cmd(op, lane, 5, 5, 7);
         end
      end

      // R6: in-place update, destination equals source 1
      conv_write(7, pat[6]);
      run_cmd(11, 1, 7, 3, 7);
      run_cmd(12, 0, 7, 1, 7);

      // R9: conventional access and a second command while busy are refused
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'd5; cmd_lane = 2'd0;
      cmd_src1 = 3'd4; cmd_src2 = 3'd5; cmd_dst = 3'd7;
      @(negedge clk);
      cmd_op = 4'd1; cmd_dst = 3'd6;
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = 3'd3; mem_wdata = ~model[3];
      @(negedge clk);
      chk(mem_rvalid === 1'b0, "R9 no rvalid while busy", LW'(mem_rvalid), '0);
      cmd_valid = 1'b0;
      mem_we = 1'b0;
      @(negedge clk);
      chk(mem_rvalid === 1'b0, "R9 read refused while busy", LW'(mem_rvalid), '0);
      chk(done === 1'b1, "R9 original command still on schedule", LW'(done), LW'(1));
      mem_en = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0, "R9 second command ignored", LW'(busy), '0);
      model[7] = model[4] ^ model[5];
      conv_read(3, "R9 line unchanged by refused write");
      conv_read(6, "R9 ignored command wrote nothing");
      conv_read(7, "R9 accepted command result");

      // R10: command wins over a simultaneous conventional write
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'd2; cmd_dst = 3'd7;
      mem_en = 1'b1; mem_we = 1'b1; mem_addr = 3'd2; mem_wdata = '1;
      @(negedge clk);
      cmd_valid = 1'b0; mem_en = 1'b0; mem_we = 1'b0;
      chk(busy === 1'b1, "R10 command accepted", LW'(busy), LW'(1));
      repeat (3) @(negedge clk);
      model[7] = '0;
      conv_read(2, "R10 conventional write refused");
      conv_read(7, "R10 command result");

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule